// File: doc/BRIEF.md
# Burst Bus Initiator

This block is the initiator side of a shared parallel bus with a multiplexed address/data path. A local requester presents a start address, a 4-bit bus command and a beat count. The block then runs one address phase, in which it drives the address and the command, followed by as many data phases as the beat count asks for. Each data beat completes in a cycle where the initiator-ready and target-ready strobes are both active. The local side is told of every completed beat by a one-cycle pulse.

The local side can hold off a beat through a wait input. Once the block has signalled ready for a beat, it holds that beat: ready and the frame strobe stay frozen until the target takes the beat. The frame strobe is released together with the ready strobe for the final beat. A back-to-back input allows a queued request to start its address phase in the cycle right after the last beat. Without it, the bus goes idle for at least one cycle first. The frame, initiator-ready and target-ready pins are active-low.

Top module: `burst_initiator`

## Requirements
- R1: During and right after reset, frameN and irdyN are high, adOe is low, busy is low and beatDone is low.
- R2: A start seen at a clock edge while idle gives an address phase in the next cycle. In that cycle frameN is low, irdyN is high, adOe is high, adOut is the request address, cbeN is the command and busy is high.
- R3: Data phases begin in the cycle after the address phase. A beat completes in every cycle where irdyN and trdyN are both low, and beatDone is high in exactly those cycles. On a read beat, rdData equals adIn.
- R4: In a data phase where no beat is being held, a high localWait keeps irdyN high. This is an initiator wait state.
- R5: Once irdyN has gone low, irdyN and frameN stay unchanged until the beat completes, whatever localWait and trdyN do.
- R6: While more than one beat remains, frameN stays low through the data phases. For the final beat, frameN goes high in the same cycle that irdyN goes low. For a single-beat request this can be the first data cycle.
- R7: A request produces exactly reqBeats beat completions. A request with reqBeats of 0 is handled as a single beat.
- R8: Bit 0 of the command selects the direction, with 1 meaning write. During write data phases, adOe is high and adOut equals wrData. During read data phases, adOe is low. In data phases, cbeN is 4'b0000, with all byte lanes enabled.
- R9: If the final beat completes while backToBack is low, the next cycle is idle: frameN and irdyN are high and busy is low. A start held through the final beat is taken only in that idle cycle.
- R10: If the final beat completes while backToBack and start are both high, the next cycle is the address phase of the new request, with its address and command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request valid |
| reqAddr | input | 32 | Request start address |
| reqCmd | input | 4 | Bus command; bit 0 set means write |
| reqBeats | input | 8 | Number of data beats; 0 is taken as 1 |
| wrData | input | 32 | Write data for the current beat |
| localWait | input | 1 | Local side not ready for the beat |
| backToBack | input | 1 | Let a queued request follow the last beat directly |
| busy | output | 1 | Transaction in progress |
| beatDone | output | 1 | Beat completed this cycle |
| rdData | output | 32 | Read data captured on the bus |
| trdyN | input | 1 | Target ready, active low |
| adIn | input | 32 | Address/data bus as seen on the pins |
| adOut | output | 32 | Address/data value driven by the block |
| adOe | output | 1 | Output enable for adOut |
| cbeN | output | 4 | Command / byte enables, active low |
| frameN | output | 1 | Frame strobe, active low |
| irdyN | output | 1 | Initiator ready, active low |

## Verification
The hardest case to reach from the ports is a held beat. Here the block has already signalled ready, the target keeps trdyN high for several cycles, and localWait rises during that stall. The bench reaches it with per-cycle target-ready and local-wait patterns in its vector table that make the two overlap. It also uses a final beat that the initiator delays, so that releasing frameN has to wait for irdyN. The back-to-back handoff is set up separately: start and backToBack are raised exactly in the final-beat cycle.

// File: rtl/burst_init_pkg.sv
package burst_init_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } busState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadReq;
    logic addrPhase;
    logic dataPhase;
  } strobe_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_init_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] reqBeats,
  input  logic             localWait,
  input  logic             backToBack,
  input  logic             trdy,
  output strobe_t          strb,
  output logic             frame,
  output logic             irdy,
  output logic             beatDone,
  output logic             busy
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  busState_t        state;
  logic [CNT_W-1:0] remaining;
  logic             committed;
  logic             beatFire;
  logic             lastFire;
  logic             accept;

  always_comb begin
    irdy     = (state == ST_DATA) && (committed || !localWait);
    beatFire = irdy && trdy;
    lastFire = beatFire && (remaining == ONE);
    accept   = start && ((state == ST_IDLE) || (lastFire && backToBack));
    frame    = (state == ST_ADDR) ||
               ((state == ST_DATA) && ((remaining > ONE) || !irdy));
    busy     = (state != ST_IDLE);
    beatDone = beatFire;
    strb.loadReq   = accept;
    strb.addrPhase = (state == ST_ADDR);
    strb.dataPhase = (state == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      committed <= 1'b0;
    end else begin
      if (beatFire)  committed <= 1'b0;
      else if (irdy) committed <= 1'b1;

      if (accept)        remaining <= (reqBeats == '0) ? ONE : reqBeats;
      else if (beatFire) remaining <= remaining - ONE;

      unique case (state)
        ST_IDLE: if (accept) state <= ST_ADDR;
        ST_ADDR: state <= ST_DATA;
        ST_DATA: if (lastFire) state <= accept ? ST_ADDR : ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: a held beat freezes ready and frame
  assert_commit_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irdy && !trdy) |=> (irdy && (frame == $past(frame))));

  // R6: frame released in a data phase only together with ready
  assert_frame_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DATA) && !frame) |-> irdy);

  // R9: final beat without back-to-back leads to an idle bus
  assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lastFire && !accept) |=> (!frame && !irdy && !busy));

  // R10: back-to-back handoff goes straight to an address phase
  assert_b2b_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lastFire && accept) |=> (frame && !irdy && (state == ST_ADDR)));

  // R7: the beat counter never runs dry inside a data phase
  assert_count_live_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (remaining != '0));

endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_init_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [ADDR_W-1:0] adIn,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  output logic [CMD_W-1:0]  cbeN,
  output logic [ADDR_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [CMD_W-1:0]  cmdQ;
  logic              isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      cmdQ  <= '0;
    end else if (strb.loadReq) begin
      addrQ <= reqAddr;
      cmdQ  <= reqCmd;
    end
  end

  always_comb begin
    isWrite = cmdQ[0];
    adOe    = strb.addrPhase || (strb.dataPhase && isWrite);
    if (strb.addrPhase)                adOut = addrQ;
    else if (strb.dataPhase && isWrite) adOut = wrData;
    else                               adOut = '0;
    if (strb.addrPhase)      cbeN = cmdQ;
    else if (strb.dataPhase) cbeN = '0;
    else                     cbeN = '1;
    rdData = adIn;
  end

  // R8: the bus is released during read data phases
  assert_read_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataPhase && !isWrite) |-> !adOe);

  // R2: address and data phases never overlap
  assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.addrPhase && strb.dataPhase));

endmodule

// File: rtl/burst_initiator.sv
module burst_initiator
  import burst_init_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic [CNT_W-1:0]  reqBeats,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              localWait,
  input  logic              backToBack,
  output logic              busy,
  output logic              beatDone,
  output logic [ADDR_W-1:0] rdData,
  input  logic              trdyN,
  input  logic [ADDR_W-1:0] adIn,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  output logic [CMD_W-1:0]  cbeN,
  output logic              frameN,
  output logic              irdyN
);

  strobe_t strb;
  logic    frame;
  logic    irdy;

  burst_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .reqBeats(reqBeats),
    .localWait(localWait), .backToBack(backToBack), .trdy(!trdyN),
    .strb(strb), .frame(frame), .irdy(irdy), .beatDone(beatDone), .busy(busy)
  );

  burst_dp #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqCmd(reqCmd),
    .wrData(wrData), .adIn(adIn), .adOut(adOut), .adOe(adOe), .cbeN(cbeN),
    .rdData(rdData)
  );

  assign frameN = !frame;
  assign irdyN  = !irdy;

endmodule

// File: tb/tb_burst_initiator.sv
module tb_burst_initiator;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] beats;
    logic [3:0] cmd;
    logic [7:0] trdyPat;
    logic [7:0] waitPat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 4'h7, 8'hFF, 8'h00},
    '{8'd4, 4'h6, 8'hFF, 8'h00},
    '{8'd3, 4'h7, 8'hAA, 8'h00},
    '{8'd5, 4'h6, 8'hF0, 8'h0E},
    '{8'd0, 4'h7, 8'hFC, 8'h01},
    '{8'd6, 4'h7, 8'hFF, 8'h54}
  };

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic [31:0] reqAddr = '0;
  logic [3:0] reqCmd = '0;
  logic [7:0] reqBeats = '0;
  logic [31:0] wrData = '0;
  logic localWait = 0;
  logic backToBack = 0;
  logic trdyN = 1;
  logic [31:0] adIn = '0;
  logic busy, beatDone, adOe, frameN, irdyN;
  logic [31:0] rdData, adOut;
  logic [3:0] cbeN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  burst_initiator dut (
    .clk(clk), .rstN(rstN), .start(start), .reqAddr(reqAddr), .reqCmd(reqCmd),
    .reqBeats(reqBeats), .wrData(wrData), .localWait(localWait),
    .backToBack(backToBack), .busy(busy), .beatDone(beatDone), .rdData(rdData),
    .trdyN(trdyN), .adIn(adIn), .adOut(adOut), .adOe(adOe), .cbeN(cbeN),
    .frameN(frameN), .irdyN(irdyN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runTxn(input vec_t v, input logic [31:0] addr);
    int rem;
    int got;
    bit comm;
    int c;
    bit isWr;
    rem = (v.beats == 0) ? 1 : int'(v.beats);
    got = 0; comm = 0; c = 0; isWr = v.cmd[0];
    @(negedge clk);
    start = 1; reqAddr = addr; reqCmd = v.cmd; reqBeats = v.beats;
    wrData = 32'hD000_0000; localWait = 0; trdyN = 1; backToBack = 0;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    #1;
    // R2 address phase
    check("R2 frameN", {31'b0, frameN}, 32'd0);
    check("R2 irdyN", {31'b0, irdyN}, 32'd1);
    check("R2 adOe", {31'b0, adOe}, 32'd1);
    check("R2 adOut", adOut, addr);
    check("R2 cbeN", {28'b0, cbeN}, {28'b0, v.cmd});
    check("R2 busy", {31'b0, busy}, 32'd1);
    @(posedge clk);
    while (rem > 0 && c < 100) begin
      bit ti, lw, expIrdy, fire;
      @(negedge clk);
      ti = v.trdyPat[c % 8];
      lw = v.waitPat[c % 8];
      trdyN = !ti; localWait = lw; adIn = 32'hA500_0000 + c;
      #1;
      expIrdy = comm || !lw;
      fire = expIrdy && ti;
      if (comm) check("R5 irdyN held", {31'b0, irdyN}, {31'b0, !expIrdy});
      else      check("R4 irdyN wait", {31'b0, irdyN}, {31'b0, !expIrdy});
      check("R6 frameN", {31'b0, frameN}, {31'b0, !((rem > 1) || !expIrdy)});
      check("R3 beatDone", {31'b0, beatDone}, {31'b0, fire});
      check("R8 cbeN data", {28'b0, cbeN}, 32'd0);
      check("R8 adOe data", {31'b0, adOe}, {31'b0, isWr});
      if (fire && isWr) check("R8 adOut write", adOut, wrData);
      if (fire && !isWr) check("R3 rdData", rdData, adIn);
      @(posedge clk);
      if (fire) begin
        rem--; got++; comm = 0;
        wrData = wrData + 1;
      end else if (expIrdy) comm = 1;
      c++;
    end
    check("R7 beat count", got, (v.beats == 0) ? 1 : v.beats);
    @(negedge clk);
    trdyN = 1; localWait = 0;
    #1;
    check("R9 idle frameN", {31'b0, frameN}, 32'd1);
    check("R9 idle irdyN", {31'b0, irdyN}, 32'd1);
    check("R9 idle busy", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    // R1 reset state
    #(CLK_PERIOD * 2 + 1);
    check("R1 frameN", {31'b0, frameN}, 32'd1);
    check("R1 irdyN", {31'b0, irdyN}, 32'd1);
    check("R1 adOe", {31'b0, adOe}, 32'd0);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 beatDone", {31'b0, beatDone}, 32'd0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #1;
    check("R1 after reset frameN", {31'b0, frameN}, 32'd1);

    for (int i = 0; i < NV; i++) runTxn(VECS[i], 32'h1000_0000 + i * 32'h100);

    // R10 back-to-back handoff
    @(negedge clk);
    start = 1; reqAddr = 32'h2222_0000; reqCmd = 4'h7; reqBeats = 8'd1;
    trdyN = 0; localWait = 0; backToBack = 0; wrData = 32'h5555_AAAA;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    @(posedge clk);
    @(negedge clk);
    start = 1; reqAddr = 32'h3333_0000; reqCmd = 4'h6; reqBeats = 8'd1; backToBack = 1;
    #1;
    check("R6 single beat frameN", {31'b0, frameN}, 32'd1);
    check("R6 single beat irdyN", {31'b0, irdyN}, 32'd0);
    check("R3 single beat done", {31'b0, beatDone}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    start = 0; backToBack = 0;
    #1;
    check("R10 frameN", {31'b0, frameN}, 32'd0);
    check("R10 adOut", adOut, 32'h3333_0000);
    check("R10 cbeN", {28'b0, cbeN}, 32'h6);
    check("R10 irdyN", {31'b0, irdyN}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    adIn = 32'hBEEF_0001;
    #1;
    check("R3 b2b read beat", {31'b0, beatDone}, 32'd1);
    check("R3 b2b rdData", rdData, 32'hBEEF_0001);
    @(posedge clk);

    // R9 start held through final beat without back-to-back
    @(negedge clk);
    start = 1; reqAddr = 32'h4444_0000; reqCmd = 4'h7; reqBeats = 8'd1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R9 final beat done", {31'b0, beatDone}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R9 gap frameN", {31'b0, frameN}, 32'd1);
    check("R9 gap busy", {31'b0, busy}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    start = 0;
    #1;
    check("R9 restart frameN", {31'b0, frameN}, 32'd0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    trdyN = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule